// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block holds the time of day and the calendar date as packed BCD bytes and advances them once per second. A free-running reference pulse `osc_tick` goes into a sub-second prescaler. Every `TICKS_PER_SEC` counted pulses the prescaler produces one internal second strobe. That strobe moves a ripple of BCD counters: seconds, minutes, hours (12-hour or 24-hour format), weekday, date, month, and a two-digit year whose range a century bit extends.

A host reaches the registers through a byte-wide port. A single address serves reads and writes. Reads are combinational. A write takes effect at the clock edge on which `reg_wr` is sampled high. Writing any time or date byte restarts the prescaler, so the first increment after the write comes one full second later. A control byte can stop timekeeping. A status byte carries a sticky flag that records a reset or a stop; the host must acknowledge it.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the time and date bytes read as seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01 and year 0x00. The control byte reads 0x00 and the status byte reads 0x80.
- R2: The byte map is: 0x0 seconds (7 bits), 0x1 minutes (7 bits), 0x2 hours (7 bits), 0x3 weekday (3 bits), 0x4 date (6 bits), 0x5 month (bits 4:0, century at bit 7), 0x6 year (8 bits), 0xE control (bit 7 only) and 0xF status (bit 7 only). Unstored bits and unmapped addresses read 0.
- R3: The seconds byte advances on the clock edge that counts the `TICKS_PER_SEC`-th `osc_tick` pulse after the last write to addresses 0x0 to 0x6. Such a write restarts the count from zero.
- R4: Seconds and minutes count 00 to 59 in BCD. At 59 each wraps to 00 and carries into the next byte up.
- R5: With hours bit 6 = 0 the hour counts 00 to 23 in BCD. The step from 23 to 00 advances the date and the weekday.
- R6: With hours bit 6 = 1, bits 4:0 hold a BCD hour in the order 12, 01 … 11 and bit 5 is the PM flag. The 11-to-12 step toggles PM, and the date and weekday advance on the step from 11 PM to 12 AM.
- R7: Weekday counts 1 to 7 and wraps from 7 to 1 at each day advance.
- R8: The date wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11, 31 for the other months except February, and for February 29 when the BCD year is divisible by 4 (00 included), otherwise 28.
- R9: Month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and toggles the century bit (month bit 7).
- R10: While control bit 7 is 1, the oscillator is stopped: the prescaler and all counters hold. Host writes still take effect.
- R11: Status bit 7 is set by reset and in every cycle after one in which the oscillator was stopped. Writing 0 to it clears it only while the oscillator runs. Writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_tick | input | 1 | Sub-second reference pulse, one count per cycle high |
| reg_addr | input | 4 | Byte address for read and write |
| reg_wr | input | 1 | Write strobe for the addressed byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed byte (combinational) |

## Verification
A read returns in the same cycle the address is presented, and a written byte reads back from the next cycle. The bench therefore sets the address at a falling edge and samples 1 ns later. A counter step is due on the rising edge that samples the last of exactly `TICKS_PER_SEC` high `osc_tick` cycles after the final setup write. The bench drives exactly that many cycles and reads at the following falling edge, and it also checks that one cycle fewer leaves the seconds byte unchanged. The stop flag is due one cycle after the control write lands, and the bench checks it at the next read.

// File: rtl/rtc_cal_pkg.sv
// Shared constants and BCD helpers for the calendar counter.
// Assumes all counter values handled here are packed BCD.
package rtc_cal_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_SEC   = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_MIN   = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_HOUR  = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_WDAY  = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_DATE  = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_MONTH = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_YEAR  = 4'h6;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 4'hF;

    // Adds one to a two-digit packed BCD value (no upper bound applied).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is a multiple of 4 when 2*tens + ones is (10 = 2 mod 4).
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    // Last valid BCD date of a BCD month in a given BCD year.
    function automatic logic [5:0] bcd_month_end(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return bcd_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
// Sub-second prescaler: counts osc_tick pulses while running and flags the
// cycle that completes one second. A restart clears the count and suppresses
// the strobe in the same cycle. Assumes TICKS_PER_SEC >= 1.
module rtc_sec_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    output logic             sec_strobe,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    // Second strobe: final counted pulse of the current second.
    always_comb begin
        sec_strobe = run & tick & ~restart & (count == LAST);
    end

    // Pulse counter with restart and wrap at one second.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            count <= '0;
        else if (run && tick)
            count <= (count == LAST) ? '0 : count + 1'b1;
    end

endmodule

// File: rtl/rtc_tod_counter.sv
// Time-of-day counter: seconds, minutes and hours in packed BCD, with the
// hour byte in 24-hour (bit6=0) or 12-hour (bit6=1, bit5=PM) format.
// Host writes take priority; the prescaler guarantees no strobe on a write.
// Emits day_carry in the cycle the day rolls over.
module rtc_tod_counter
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_strobe,
    input  logic       we_sec,
    input  logic       we_min,
    input  logic       we_hour,
    input  logic [6:0] wdata,
    output logic [6:0] sec_q,
    output logic [6:0] min_q,
    output logic [6:0] hour_q,
    output logic       day_carry
);

    logic       sec_wrap, min_wrap, hour_last;
    logic [6:0] sec_nx, min_nx, hour_nx;
    logic [7:0] sec_inc, min_inc, h24_inc, h12_inc;
    logic [4:0] h12;
    logic       pm;

    // Next-value and wrap decode for the three time bytes.
    always_comb begin
        sec_wrap = (sec_q == 7'h59);
        min_wrap = (min_q == 7'h59);
        sec_inc  = bcd_inc({1'b0, sec_q});
        min_inc  = bcd_inc({1'b0, min_q});
        sec_nx   = sec_wrap ? 7'h00 : sec_inc[6:0];
        min_nx   = min_wrap ? 7'h00 : min_inc[6:0];
        h12      = hour_q[4:0];
        pm       = hour_q[5];
        h24_inc  = bcd_inc({2'b00, hour_q[5:0]});
        h12_inc  = bcd_inc({3'b000, h12});
        if (hour_q[6]) begin
            hour_last = (h12 == 5'h11) & pm;
            if (h12 == 5'h12)
                hour_nx = {1'b1, pm, 5'h01};
            else if (h12 == 5'h11)
                hour_nx = {1'b1, ~pm, 5'h12};
            else
                hour_nx = {1'b1, pm, h12_inc[4:0]};
        end else begin
            hour_last = (hour_q[5:0] == 6'h23);
            hour_nx   = hour_last ? 7'h00 : {1'b0, h24_inc[5:0]};
        end
        day_carry = sec_strobe & sec_wrap & min_wrap & hour_last;
    end

    // Seconds register.
    always_ff @(posedge clk) begin
        if (!rst_n)          sec_q <= 7'h00;
        else if (we_sec)     sec_q <= wdata;
        else if (sec_strobe) sec_q <= sec_nx;
    end

    // Minutes register, carried from seconds.
    always_ff @(posedge clk) begin
        if (!rst_n)                      min_q <= 7'h00;
        else if (we_min)                 min_q <= wdata;
        else if (sec_strobe && sec_wrap) min_q <= min_nx;
    end

    // Hours register, carried from minutes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  hour_q <= 7'h00;
        else if (we_hour)                            hour_q <= wdata;
        else if (sec_strobe && sec_wrap && min_wrap) hour_q <= hour_nx;
    end

endmodule

// File: rtl/rtc_date_counter.sv
// Calendar counter: weekday 1..7, BCD date with month-length wrap (leap
// February on years divisible by 4), BCD month 1..12, BCD year 00..99 and a
// century bit toggled on the year wrap. Advances once per day_carry.
module rtc_date_counter
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_carry,
    input  logic       we_wday,
    input  logic       we_date,
    input  logic       we_month,
    input  logic       we_year,
    input  logic [7:0] wdata,
    output logic [2:0] wday_q,
    output logic [5:0] date_q,
    output logic [4:0] month_q,
    output logic       century_q,
    output logic [7:0] year_q
);

    logic       date_wrap, month_wrap, year_wrap;
    logic [7:0] date_inc, month_inc, year_inc;

    // Wrap and increment decode for the date bytes.
    always_comb begin
        date_wrap  = (date_q == bcd_month_end(month_q, year_q));
        month_wrap = (month_q == 5'h12);
        year_wrap  = (year_q == 8'h99);
        date_inc   = bcd_inc({2'b00, date_q});
        month_inc  = bcd_inc({3'b000, month_q});
        year_inc   = bcd_inc(year_q);
    end

    // Weekday register, 7 wraps to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)         wday_q <= 3'd1;
        else if (we_wday)   wday_q <= wdata[2:0];
        else if (day_carry) wday_q <= (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
    end

    // Date register, wraps at the end of the current month.
    always_ff @(posedge clk) begin
        if (!rst_n)         date_q <= 6'h01;
        else if (we_date)   date_q <= wdata[5:0];
        else if (day_carry) date_q <= date_wrap ? 6'h01 : date_inc[5:0];
    end

    // Month register and century bit, written together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            month_q   <= 5'h01;
            century_q <= 1'b0;
        end else if (we_month) begin
            month_q   <= wdata[4:0];
            century_q <= wdata[7];
        end else if (day_carry && date_wrap) begin
            month_q <= month_wrap ? 5'h01 : month_inc[4:0];
            if (month_wrap && year_wrap)
                century_q <= ~century_q;
        end
    end

    // Year register, carried from month.
    always_ff @(posedge clk) begin
        if (!rst_n)
            year_q <= 8'h00;
        else if (we_year)
            year_q <= wdata;
        else if (day_carry && date_wrap && month_wrap)
            year_q <= year_wrap ? 8'h00 : year_inc;
    end

endmodule

// File: rtl/rtc_bcd_calendar.sv
// Top of the BCD calendar counter. Decodes the byte-wide host port, holds
// the oscillator-stop control bit and the sticky stop flag, and ties the
// prescaler to the time and date counters. Reads are combinational.
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);

    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

    logic             wr_time;
    logic             osc_off, osf;
    logic             sec_strobe, day_carry;
    logic [CNT_W-1:0] presc_cnt;
    logic [6:0]       sec_q, min_q, hour_q;
    logic [2:0]       wday_q;
    logic [5:0]       date_q;
    logic [4:0]       month_q;
    logic             century_q;
    logic [7:0]       year_q;

    // Any write to a time or date byte restarts the second.
    always_comb begin
        wr_time = reg_wr && (reg_addr <= ADR_YEAR);
    end

    rtc_sec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (~osc_off),
        .tick       (osc_tick),
        .restart    (wr_time),
        .sec_strobe (sec_strobe),
        .count      (presc_cnt)
    );

    rtc_tod_counter u_tod (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_strobe (sec_strobe),
        .we_sec     (reg_wr && reg_addr == ADR_SEC),
        .we_min     (reg_wr && reg_addr == ADR_MIN),
        .we_hour    (reg_wr && reg_addr == ADR_HOUR),
        .wdata      (reg_wdata[6:0]),
        .sec_q      (sec_q),
        .min_q      (min_q),
        .hour_q     (hour_q),
        .day_carry  (day_carry)
    );

    rtc_date_counter u_date (
        .clk        (clk),
        .rst_n      (rst_n),
        .day_carry  (day_carry),
        .we_wday    (reg_wr && reg_addr == ADR_WDAY),
        .we_date    (reg_wr && reg_addr == ADR_DATE),
        .we_month   (reg_wr && reg_addr == ADR_MONTH),
        .we_year    (reg_wr && reg_addr == ADR_YEAR),
        .wdata      (reg_wdata),
        .wday_q     (wday_q),
        .date_q     (date_q),
        .month_q    (month_q),
        .century_q  (century_q),
        .year_q     (year_q)
    );

    // Oscillator-stop control bit (1 = stopped).
    always_ff @(posedge clk) begin
        if (!rst_n)
            osc_off <= 1'b0;
        else if (reg_wr && reg_addr == ADR_CTRL)
            osc_off <= reg_wdata[7];
    end

    // Sticky stop flag: set by reset or a stopped oscillator, host-cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            osf <= 1'b1;
        else if (osc_off)
            osf <= 1'b1;
        else if (reg_wr && reg_addr == ADR_STAT && !reg_wdata[7])
            osf <= 1'b0;
    end

    // Read multiplexer; unstored bits and unmapped addresses read zero.
    always_comb begin
        case (reg_addr)
            ADR_SEC:   reg_rdata = {1'b0, sec_q};
            ADR_MIN:   reg_rdata = {1'b0, min_q};
            ADR_HOUR:  reg_rdata = {1'b0, hour_q};
            ADR_WDAY:  reg_rdata = {5'b0, wday_q};
            ADR_DATE:  reg_rdata = {2'b0, date_q};
            ADR_MONTH: reg_rdata = {century_q, 2'b0, month_q};
            ADR_YEAR:  reg_rdata = year_q;
            ADR_CTRL:  reg_rdata = {osc_off, 7'b0};
            ADR_STAT:  reg_rdata = {osf, 7'b0};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
// Property checker for the calendar counter, bound to the top module.
// Observes the prescaler, the control and flag bits and the counter bytes.
module rtc_bcd_calendar_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_time,
    input logic             sec_strobe,
    input logic             osc_off,
    input logic             osf,
    input logic [CNT_W-1:0] presc_cnt,
    input logic [6:0]       sec_q,
    input logic [7:0]       year_q,
    input logic             century_q
);

    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_time) |-> (presc_cnt == '0));

    assert_sec_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sec_strobe) && !$past(wr_time)) |-> $stable(sec_q));

    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_strobe) && $past(sec_q) == 7'h59) |-> (sec_q == 7'h00));

    assert_century_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_time) && !$stable(century_q)) |-> (year_q == 8'h00 && $past(year_q) == 8'h99));

    assert_hold_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osc_off) && !$past(wr_time)) |-> $stable(sec_q));

    assert_flag_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(osc_off) |-> osf);

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_time    (wr_time),
    .sec_strobe (sec_strobe),
    .osc_off    (osc_off),
    .osf        (osf),
    .presc_cnt  (presc_cnt),
    .sec_q      (sec_q),
    .year_q     (year_q),
    .century_q  (century_q)
);

// File: tb/rtc_bcd_calendar_tb.sv
// Sweep bench for the calendar counter with a 4-pulse second.
module rtc_bcd_calendar_tb;

    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    rtc_bcd_calendar #(.TICKS_PER_SEC(TPS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int days_in(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // 12-hour encoding of a 0..23 hour.
    function automatic logic [7:0] enc12(input int idx);
        int h;
        h = idx % 12;
        if (h == 0) h = 12;
        return 8'h40 | ((idx >= 12) ? 8'h20 : 8'h00) | bcd(h);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        osc_tick = 1'b1;
        repeat (n) @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_checks++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr %h: got %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic set_all(input logic [7:0] s, m, h, wd, d, mo, y);
        wr(4'h0, s); wr(4'h1, m); wr(4'h2, h); wr(4'h3, wd);
        wr(4'h4, d); wr(4'h5, mo); wr(4'h6, y);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk("R1", 4'h0, 8'h00); chk("R1", 4'h1, 8'h00); chk("R1", 4'h2, 8'h00);
        chk("R1", 4'h3, 8'h01); chk("R1", 4'h4, 8'h01); chk("R1", 4'h5, 8'h01);
        chk("R1", 4'h6, 8'h00); chk("R1", 4'hE, 8'h00); chk("R1", 4'hF, 8'h80);

        // R11: flag clear and write-1 no effect while running
        wr(4'hF, 8'h00); chk("R11", 4'hF, 8'h00);
        wr(4'hF, 8'h80); chk("R11", 4'hF, 8'h00);

        // R2: unstored bits read zero
        wr(4'h0, 8'hFF); chk("R2", 4'h0, 8'h7F);
        wr(4'h3, 8'hFF); chk("R2", 4'h3, 8'h07);
        wr(4'h4, 8'hFF); chk("R2", 4'h4, 8'h3F);
        wr(4'h5, 8'hFF); chk("R2", 4'h5, 8'h9F);
        wr(4'hE, 8'h7F); chk("R2", 4'hE, 8'h00);
        wr(4'h8, 8'hFF); chk("R2", 4'h8, 8'h00);

        // R3: second completes on the TPS-th pulse after a time write
        wr(4'h0, 8'h20);
        ticks(TPS - 1); chk("R3", 4'h0, 8'h20);
        ticks(1);       chk("R3", 4'h0, 8'h21);
        ticks(2); wr(4'h0, 8'h30);
        ticks(TPS - 1); chk("R3", 4'h0, 8'h30);
        ticks(1);       chk("R3", 4'h0, 8'h31);

        // R10, R11: stopped oscillator holds counters and sets the flag
        wr(4'hE, 8'h80); chk("R10", 4'hE, 8'h80);
        wr(4'h0, 8'h10);
        ticks(3 * TPS); chk("R10", 4'h0, 8'h10);
        chk("R11", 4'hF, 8'h80);
        wr(4'hF, 8'h00); chk("R11", 4'hF, 8'h80);
        wr(4'hE, 8'h00); wr(4'hF, 8'h00); chk("R11", 4'hF, 8'h00);
        ticks(TPS); chk("R10", 4'h0, 8'h11);

        // R4: seconds sweep with minute carry
        for (int s = 0; s < 60; s++) begin
            wr(4'h1, 8'h42); wr(4'h0, bcd(s));
            ticks(TPS);
            chk("R4", 4'h0, bcd((s + 1) % 60));
            chk("R4", 4'h1, (s == 59) ? 8'h43 : 8'h42);
        end
        // R4: minute wrap carries into hour
        wr(4'h2, 8'h05); wr(4'h1, 8'h59); wr(4'h0, 8'h59);
        ticks(TPS);
        chk("R4", 4'h1, 8'h00); chk("R4", 4'h2, 8'h06);

        // R5, R7: 24-hour sweep, day advance and weekday 7 -> 1
        for (int h = 0; h < 24; h++) begin
            set_all(8'h59, 8'h59, bcd(h), 8'h07, 8'h10, 8'h05, 8'h24);
            ticks(TPS);
            chk("R5", 4'h2, bcd((h + 1) % 24));
            chk("R5", 4'h4, (h == 23) ? 8'h11 : 8'h10);
            chk("R7", 4'h3, (h == 23) ? 8'h01 : 8'h07);
        end

        // R6: 12-hour sweep including PM toggles and day advance
        for (int i = 0; i < 24; i++) begin
            set_all(8'h59, 8'h59, enc12(i), 8'h02, 8'h10, 8'h05, 8'h24);
            ticks(TPS);
            chk("R6", 4'h2, enc12((i + 1) % 24));
            chk("R6", 4'h4, (i == 23) ? 8'h11 : 8'h10);
        end

        // R8, R9: month-end sweep across leap, common and 00 years
        for (int yi = 0; yi < 3; yi++) begin
            int y;
            y = (yi == 0) ? 23 : ((yi == 1) ? 24 : 0);
            for (int m = 1; m <= 12; m++) begin
                set_all(8'h59, 8'h59, 8'h23, 8'h03, bcd(days_in(m, y)), bcd(m), bcd(y));
                ticks(TPS);
                chk("R8", 4'h4, 8'h01);
                chk("R9", 4'h5, bcd((m == 12) ? 1 : m + 1));
                chk("R9", 4'h6, bcd((m == 12) ? (y + 1) % 100 : y));
                chk("R7", 4'h3, 8'h04);
            end
            // R8: the day before February's end does not wrap
            set_all(8'h59, 8'h59, 8'h23, 8'h03, bcd(days_in(2, y) - 1), 8'h02, bcd(y));
            ticks(TPS);
            chk("R8", 4'h4, bcd(days_in(2, y)));
        end

        // R9: year 99 -> 00 toggles the century bit both ways
        set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
        ticks(TPS);
        chk("R9", 4'h5, 8'h81); chk("R9", 4'h6, 8'h00);
        set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h92, 8'h99);
        ticks(TPS);
        chk("R9", 4'h5, 8'h01); chk("R9", 4'h6, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule